// File: doc/BRIEF.md
# Push-pull gate driver with dead-time

This block turns a switching reference into two gate-drive signals for the two primary-side switches of a push-pull transformer stage. It runs on a fast system clock. The reference comes from one of two places. The first is an external clock pin, once that pin has been measured and found to be in range. The second is an internal divider that stands in for an on-chip oscillator. Every rising edge of the selected reference marks a phase boundary. The boundaries alternate the drive between the two outputs, which divides the reference by two into complementary halves.

At each boundary both outputs drop. A programmable dead-time, counted in system clock cycles, must pass before the output for the new phase rises. An enable input and an undervoltage-lockout flag gate the whole path. A third output reports which reference is in use. The block falls back to the internal source by itself when the external clock stops or runs outside its allowed period window. A change of source takes effect only on a phase boundary.

Top module: `pushpull_gate_drv`

## Requirements
- R1: The selected reference is divided by two. Each boundary hands the drive to the other output, so G1 and G2 pulses alternate. With the internal source a boundary occurs every INT_HALF (default 236) system cycles.
- R2: g1_o and g2_o are never high in the same cycle. Before either one rises, both have been low for at least one cycle.
- R3: After each boundary, both outputs stay low for exactly max(dead_i, 1) system cycles before the active output rises. A dead_i value of 0 behaves as 1.
- R4: In steady state the G1 and G2 high times are equal. Each equals the boundary spacing minus the dead-time (internal source: INT_HALF − dead).
- R5: While en_i is 0, both outputs are low from the same cycle on and the phase state is idle. After en_i rises, the first pulse is on G1 and starts after max(dead_i,1) cycles.
- R6: When uvlo_i is 1, both outputs go low in the same cycle. After it clears, the first pulse is on G1, following a full dead-time.
- R7: The external clock becomes valid only after LOCK_CNT (default 4) consecutive rising-edge periods lie within EXT_MIN_PER..EXT_MAX_PER system cycles (defaults 125..2000). ext_sel_o then goes to 1, and boundaries follow the external rising edges.
- R8: If no external rising edge arrives within EXT_MAX_PER cycles, the external clock is declared lost and the driver returns to the internal source (ext_sel_o = 0).
- R9: An external clock whose period is shorter than EXT_MIN_PER or longer than EXT_MAX_PER never gets selected.
- R10: ext_sel_o changes only on a phase boundary, so in the cycle where it changes both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Driver enable |
| uvlo_i | input | 1 | Undervoltage lockout flag, active high |
| ext_clk_i | input | 1 | External switching clock, asynchronous |
| dead_i | input | DT_W | Dead-time in system cycles (0 treated as 1) |
| g1_o | output | 1 | Gate drive, first switch |
| g2_o | output | 1 | Gate drive, second switch |
| ext_sel_o | output | 1 | 1 when the external clock is the active reference |

## Verification
The bench counts the exact dead gap and the two high widths, with both the internal reference and a locked external one. A design that loaded the dead counter off by one, or forgot to clamp zero, would show a gap of 9, 11 or 0 cycles. A design whose phases drifted would show unequal widths. Enable and lockout are dropped in the middle of a pulse. A design that registered the gating would leave a stray high cycle, and one that did not reset the phase would restart on G2. The external pin is driven in range, too fast, too slow and then silent. A monitor without hysteresis or loss detection would select an unusable clock, or would switch source with an output still high.

// File: rtl/ppdrv_pkg.sv
package ppdrv_pkg;
  typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} src_e;

  function automatic int unsigned cnt_w(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/ppdrv_clk_mon.sv
module ppdrv_clk_mon #(
  parameter int unsigned MIN_PER     = 125,
  parameter int unsigned MAX_PER     = 2000,
  parameter int unsigned LOCK_CNT    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_clk_i,
  output logic rise_o,
  output logic valid_o
);
  localparam int unsigned PW = ppdrv_pkg::cnt_w(MAX_PER);
  localparam int unsigned LW = ppdrv_pkg::cnt_w(LOCK_CNT);
  localparam logic [PW-1:0] LIM_LO = PW'(MIN_PER - 1);
  localparam logic [PW-1:0] LIM_HI = PW'(MAX_PER - 1);
  localparam logic [PW-1:0] SAT    = PW'(MAX_PER);
  localparam logic [LW-1:0] LOCK_LAST = LW'(LOCK_CNT - 1);

  logic [SYNC_STAGES:0] sync_q;
  logic [PW-1:0]        per_q;
  logic [LW-1:0]        good_q;
  logic                 valid_q;
  logic                 in_rng;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk_i};
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  // per_q holds period-1 at the rising edge; saturated means no reference edge
  assign in_rng = (per_q >= LIM_LO) && (per_q <= LIM_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q   <= SAT;
      good_q  <= '0;
      valid_q <= 1'b0;
    end else if (rise_o) begin
      per_q <= '0;
      if (in_rng) begin
        if (good_q == LOCK_LAST) valid_q <= 1'b1;
        else                     good_q  <= good_q + 1'b1;
      end else begin
        good_q  <= '0;
        valid_q <= 1'b0;
      end
    end else if (per_q != SAT) begin
      per_q <= per_q + 1'b1;
    end else begin
      good_q  <= '0;
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;

  AST_VALID_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(rise_o)); // R7

  AST_LOSS_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_q == SAT && !rise_o) |=> !valid_q); // R8
endmodule

// File: rtl/ppdrv_int_osc.sv
module ppdrv_int_osc #(
  parameter int unsigned HALF = 236
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = ppdrv_pkg::cnt_w(HALF);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ppdrv_gate_phase.sv
module ppdrv_gate_phase #(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            bound_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            g1_o,
  output logic            g2_o
);
  logic            ph_q;   // 0: G1 phase, 1: G2 phase
  logic            on_q;
  logic [DT_W-1:0] dt_q;
  logic [DT_W-1:0] dt_eff;

  assign dt_eff = (dead_i == '0) ? DT_W'(1) : dead_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= 1'b0;
      on_q <= 1'b0;
      dt_q <= '1;
    end else if (!run_i) begin
      ph_q <= 1'b0;
      on_q <= 1'b0;
      dt_q <= dt_eff;
    end else if (bound_i) begin
      // hand over only after a pulse was driven, keeps strict alternation
      ph_q <= on_q ? ~ph_q : ph_q;
      on_q <= 1'b0;
      dt_q <= dt_eff;
    end else if (dt_q != '0) begin
      dt_q <= dt_q - 1'b1;
      if (dt_q == DT_W'(1)) on_q <= 1'b1;
    end
  end

  assign g1_o = on_q & ~ph_q & run_i;
  assign g2_o = on_q &  ph_q & run_i;

  AST_GAP_BEFORE_G1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(g1_o) |-> !$past(g2_o)); // R2

  AST_GAP_BEFORE_G2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(g2_o) |-> !$past(g1_o)); // R2

  AST_IDLE_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !on_q && !ph_q); // R5
endmodule

// File: rtl/pushpull_gate_drv.sv
module pushpull_gate_drv #(
  parameter int unsigned DT_W        = 8,
  parameter int unsigned INT_HALF    = 236,
  parameter int unsigned EXT_MIN_PER = 125,
  parameter int unsigned EXT_MAX_PER = 2000,
  parameter int unsigned LOCK_CNT    = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            uvlo_i,
  input  logic            ext_clk_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            g1_o,
  output logic            g2_o,
  output logic            ext_sel_o
);
  import ppdrv_pkg::*;

  logic run, ext_rise, ext_valid, int_tick, tick_sel, lost, bound;
  src_e src_q;

  assign run = en_i & ~uvlo_i;

  ppdrv_clk_mon #(
    .MIN_PER(EXT_MIN_PER), .MAX_PER(EXT_MAX_PER),
    .LOCK_CNT(LOCK_CNT), .SYNC_STAGES(2)
  ) u_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_clk_i(ext_clk_i),
    .rise_o(ext_rise), .valid_o(ext_valid)
  );

  ppdrv_int_osc #(.HALF(INT_HALF)) u_osc (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_o(int_tick)
  );

  assign tick_sel = (src_q == SRC_EXT) ? ext_rise : int_tick;
  assign lost     = (src_q == SRC_EXT) & ~ext_valid;
  assign bound    = run & (tick_sel | lost);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            src_q <= SRC_INT;
    else if (!run || bound) src_q <= ext_valid ? SRC_EXT : SRC_INT;
  end

  ppdrv_gate_phase #(.DT_W(DT_W)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .bound_i(bound),
    .dead_i(dead_i), .g1_o(g1_o), .g2_o(g2_o)
  );

  assign ext_sel_o = (src_q == SRC_EXT);

  AST_SRC_AT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_q != $past(src_q)) |-> $past(bound || !run)); // R10

  AST_EXT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_sel_o) |-> $past(ext_valid)); // R7
endmodule

// File: tb/pushpull_gate_drv_test.sv
module pushpull_gate_drv_test;
  localparam int DT_W = 8;
  localparam int HALF = 236;
  localparam int EXT_MAX = 2000;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, uvlo = 1'b0, ext_clk = 1'b0;
  logic [DT_W-1:0] dead = 8'd10;
  logic g1, g2, ext_sel;
  int checks = 0, errors = 0, overlap = 0;
  int ext_half = 100;
  bit ext_on = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  pushpull_gate_drv uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .uvlo_i(uvlo),
    .ext_clk_i(ext_clk), .dead_i(dead),
    .g1_o(g1), .g2_o(g2), .ext_sel_o(ext_sel)
  );

  always begin
    if (ext_on) begin
      ext_clk = 1'b1; repeat (ext_half) @(negedge clk);
      ext_clk = 1'b0; repeat (ext_half) @(negedge clk);
    end else begin
      ext_clk = 1'b0; @(negedge clk);
    end
  end

  always @(negedge clk) if (g1 && g2) overlap++;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic sig(input int w);
    return (w == 1) ? g1 : g2;
  endfunction

  task automatic wait_level(input int w, input logic lvl, input int lim, output int n);
    n = 0;
    while (sig(w) != lvl && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic count_level(input int w, input logic lvl, input int lim, output int n);
    n = 0;
    while (sig(w) == lvl && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic measure(input int hi, input int gap, input string req);
    int n, h1, h2, q1, q2;
    wait_level(1, 1'b0, 5000, n);
    wait_level(1, 1'b1, 5000, n);
    wait_level(1, 1'b0, 5000, n);
    wait_level(1, 1'b1, 5000, n);
    count_level(1, 1'b1, 5000, h1);
    count_level(2, 1'b0, 5000, q1);
    count_level(2, 1'b1, 5000, h2);
    count_level(1, 1'b0, 5000, q2);
    chk(h1 == hi, req, "G1 high width", h1, hi);
    chk(h2 == hi, req, "G2 high width", h2, hi);
    chk(q1 == gap, req, "gap G1->G2", q1, gap);
    chk(q2 == gap, req, "gap G2->G1", q2, gap);
  endtask

  task automatic t_reset();
    chk(!g1 && !g2, "R5", "outputs in reset", {30'd0, g1, g2}, 0);
    chk(!ext_sel, "R7", "ext_sel in reset", ext_sel, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!g1 && !g2, "R5", "outputs while disabled", {30'd0, g1, g2}, 0);
  endtask

  task automatic t_first_and_width();
    int n;
    dead = 8'd10;
    en = 1'b1;
    wait_level(1, 1'b1, 1000, n);
    chk(n == 10, "R5", "first G1 delay after enable", n, 10);
    measure(HALF - 10, 10, "R1 R3 R4");
  endtask

  task automatic t_dead_zero();
    int n;
    @(negedge clk); en = 1'b0; dead = 8'd0;
    @(negedge clk); en = 1'b1;
    wait_level(1, 1'b1, 1000, n);
    chk(n == 1, "R3", "first G1 delay with dead 0", n, 1);
    measure(HALF - 1, 1, "R3 clamp");
    @(negedge clk); en = 1'b0; dead = 8'd10;
    @(negedge clk);
  endtask

  task automatic t_enable_drop();
    int n, bad;
    en = 1'b1;
    wait_level(1, 1'b1, 1000, n);
    repeat (20) @(negedge clk);
    en = 1'b0; #1;
    chk(!g1 && !g2, "R5", "outputs same cycle en low", {30'd0, g1, g2}, 0);
    bad = 0;
    repeat (30) begin @(negedge clk); if (g1 || g2) bad++; end
    chk(bad == 0, "R5", "high cycles while disabled", bad, 0);
    en = 1'b1;
    wait_level(1, 1'b1, 1000, n);
    chk(n == 10, "R5", "G1 first after re-enable", n, 10);
    chk(!g2, "R5", "G2 low at first pulse", g2, 0);
  endtask

  task automatic t_uvlo();
    int n, bad;
    wait_level(2, 1'b1, 1000, n);
    repeat (15) @(negedge clk);
    uvlo = 1'b1; #1;
    chk(!g1 && !g2, "R6", "outputs same cycle uvlo", {30'd0, g1, g2}, 0);
    bad = 0;
    repeat (40) begin @(negedge clk); if (g1 || g2) bad++; end
    chk(bad == 0, "R6", "high cycles during uvlo", bad, 0);
    uvlo = 1'b0;
    wait_level(1, 1'b1, 1000, n);
    chk(n == 10, "R6", "G1 first after uvlo clears", n, 10);
  endtask

  task automatic t_ext_lock();
    int n;
    ext_half = 100; ext_on = 1'b1;
    n = 0;
    while (!ext_sel && n < 4000) begin @(negedge clk); n++; end
    chk(ext_sel, "R7", "ext selected", ext_sel, 1);
    chk(n >= 800, "R7", "lock needs LOCK_CNT periods", n, 800);
    chk(!g1 && !g2, "R10", "outputs low at source change", {30'd0, g1, g2}, 0);
    measure(200 - 10, 10, "R7 R1 R4");
  endtask

  task automatic t_ext_loss();
    int n;
    ext_on = 1'b0;
    n = 0;
    while (ext_sel && n < 4000) begin @(negedge clk); n++; end
    chk(!ext_sel, "R8", "fallback to internal", ext_sel, 0);
    chk(n <= EXT_MAX + 300, "R8", "loss detection time", n, EXT_MAX + 300);
    chk(!g1 && !g2, "R10", "outputs low at fallback", {30'd0, g1, g2}, 0);
    measure(HALF - 10, 10, "R8 R4");
  endtask

  task automatic t_ext_bad(input int half, input int cycles, input string what);
    int sel;
    ext_half = half; ext_on = 1'b1;
    sel = 0;
    repeat (cycles) begin @(negedge clk); if (ext_sel) sel++; end
    chk(sel == 0, "R9", what, sel, 0);
    ext_on = 1'b0;
    repeat (50) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_first_and_width();
    t_dead_zero();
    t_enable_drop();
    t_uvlo();
    t_ext_lock();
    t_ext_loss();
    t_ext_bad(40, 3000, "too fast ext clock selected cycles");
    measure(HALF - 10, 10, "R9 internal kept");
    t_ext_bad(1100, 9000, "too slow ext clock selected cycles");
    chk(overlap == 0, "R2", "overlap cycles", overlap, 0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule